// File: doc/BRIEF.md
# Text Row Fetch Scheduler

This block decides, cycle by cycle, what a character-cell video controller does with its single memory port. Each scan line opens with the bitmap fetches for the visible columns. A run of memory refresh cycles follows. Every cycle left on the line after that is given to prefetching the character codes of the next character row and, when attributes are enabled, its attribute bytes. The fetched bytes go into a pair of on-chip row buffers. While one buffer bank is being filled, the other bank supplies the row on screen. The two banks trade roles at each character row boundary.

Prefetch work is not tied to one line. It spreads over all the scan lines of a row, and in interlace only over the first half of them. A configuration can therefore ask for more bytes than the free cycles can deliver. When that happens the prefetch stops at the row boundary, the entries it did not reach keep their old contents, and an underrun flag is raised for the next row. The memory model, the pixel shifter and colour generation sit outside the block. All configuration inputs are expected to be held stable while the block is out of reset.

Top module: `text_row_fetch_sched`

## Requirements
- R1: A scan line lasts `htotal`+1 cycles and a character row lasts `row_lines`+1 scan lines. The line position restarts at 0 after the cycle where it equals `htotal`.
- R2: In line positions 0 to `hdisp` the slot is a bitmap fetch. `mem_kind` is 1, `mem_req` is 1 and `mem_addr` carries the line position, which is the column being drawn.
- R3: The `refresh` cycles that follow the bitmap fetches are refresh slots. `mem_kind` is 2 and `mem_addr` is an 8-bit refresh counter that starts at 0 after reset and steps by one on each refresh slot. When `refresh` is 0 there are no refresh slots.
- R4: Every other cycle on an eligible line is a prefetch slot until the row's prefetch count is reached, and an idle slot (`mem_kind` 0, `mem_req` 0) after that. Each byte type starts with 4 setup slots (`mem_kind` 3, `mem_req` 0, `mem_addr` 0). Then `hdisp`+1 character fetches (`mem_kind` 4) follow for columns 0 to `hdisp` in ascending order.
- R5: With `attr_en` set, a second segment of 4 setup slots and `hdisp`+1 attribute fetches (`mem_kind` 5) follows the character segment. This doubles the prefetch count to 2×(`hdisp`+5). With `attr_en` clear, the count is `hdisp`+5.
- R6: With `interlace` set, only scan lines 0 to ((`row_lines`+1)/2)−1 of a row are eligible for prefetch, rounding down. Later lines give idle slots instead.
- R7: Each character or attribute fetch pulses `wr_en`. Column c below 82 writes index c of the character buffer (`wr_attr` 0) or of the attribute buffer (`wr_attr` 1). Column c of 82 or more writes attribute buffer index c−81 for either byte type.
- R8: A character fetch for column c addresses `char_base`+row offset+c, and an attribute fetch addresses `attr_base`+row offset+c, both modulo 2^16. The row offset is 0 after reset and grows by `hdisp`+1 at each row boundary.
- R9: `wr_bank` names the bank being filled and `disp_bank` is always its complement. `wr_bank` toggles exactly at each row boundary.
- R10: At a row boundary, prefetch progress resets. `underrun` is set for the next row when the count reached, including the boundary cycle itself, is below the row's prefetch count, and cleared otherwise. It does not change inside a row.
- R11: After reset the line position, row line, prefetch progress, refresh counter and row offset are 0. `wr_bank` is 0 and `underrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| htotal | input | 8 | Last cycle index of a scan line |
| hdisp | input | 7 | Last displayed column index |
| refresh | input | 8 | Refresh slots per line |
| row_lines | input | 5 | Last scan line index of a character row |
| interlace | input | 1 | Restrict prefetch to the first half of each row |
| attr_en | input | 1 | Also prefetch attribute bytes |
| char_base | input | 16 | Base address of character codes |
| attr_base | input | 16 | Base address of attribute bytes |
| mem_req | output | 1 | Memory access this cycle |
| mem_kind | output | 3 | Slot type: 0 idle, 1 bitmap, 2 refresh, 3 setup, 4 character, 5 attribute |
| mem_addr | output | 16 | Memory address for this slot |
| wr_en | output | 1 | Row buffer write strobe |
| wr_attr | output | 1 | Buffer written: 0 character, 1 attribute |
| wr_idx | output | 7 | Index written in that buffer |
| wr_bank | output | 1 | Bank being filled |
| disp_bank | output | 1 | Bank being displayed |
| underrun | output | 1 | Previous row's prefetch did not finish |

## Verification
Two events can fall in the same cycle: the final prefetch fetch of a row and the row boundary that swaps banks and judges underrun. If the boundary sampled the progress count from before that cycle's fetch, a row that fits exactly would be flagged. The sweep includes a configuration whose free cycles equal the prefetch count exactly, so the last attribute fetch lands on the row's last cycle and `underrun` must stay clear. It also includes a neighbour with one free cycle fewer per line, where `underrun` must be set. Each flag value is checked against a product of free cycles and eligible lines computed in the bench, and every slot is compared with a model of the requirements.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
    localparam int HT_W      = 8;
    localparam int HD_W      = 7;
    localparam int RF_W      = 8;
    localparam int SL_W      = 5;
    localparam int AW        = 16;
    localparam int BUF_DEPTH = 82;
    localparam int SETUP_CYC = 4;
    localparam int IDX_W     = $clog2(BUF_DEPTH);
    localparam int PF_W      = HD_W + 3;
    localparam int CW        = HT_W + 2;

    typedef enum logic [2:0] {
        K_IDLE    = 3'd0,
        K_BITMAP  = 3'd1,
        K_REFRESH = 3'd2,
        K_SETUP   = 3'd3,
        K_CHAR    = 3'd4,
        K_ATTR    = 3'd5
    } slot_kind_e;

    typedef struct packed {
        logic             attr;
        logic [IDX_W-1:0] idx;
    } buf_loc_t;

    // Slots per byte type: setup plus one fetch per column.
    function automatic logic [PF_W-1:0] seg_len(input logic [HD_W-1:0] hd);
        return PF_W'(hd) + PF_W'(SETUP_CYC + 1);
    endfunction

    function automatic logic [PF_W-1:0] pf_total(input logic [HD_W-1:0] hd, input logic two);
        return two ? (seg_len(hd) << 1) : seg_len(hd);
    endfunction

    // Columns past the first buffer spill into the attribute buffer at index 1 onward.
    function automatic buf_loc_t map_col(input logic [HD_W-1:0] col, input logic is_attr);
        buf_loc_t r;
        if (int'(col) >= BUF_DEPTH) begin
            r.attr = 1'b1;
            r.idx  = IDX_W'(int'(col) - (BUF_DEPTH - 1));
        end else begin
            r.attr = is_attr;
            r.idx  = IDX_W'(col);
        end
        return r;
    endfunction
endpackage

// File: rtl/tfs_line_timer.sv
module tfs_line_timer
    import tfs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [HT_W-1:0] htotal,
    input  logic [SL_W-1:0] row_lines,
    output logic [HT_W-1:0] hpos,
    output logic [SL_W-1:0] lpos,
    output logic            line_end,
    output logic            row_end
);
    assign line_end = (hpos >= htotal);
    assign row_end  = line_end && (lpos >= row_lines);

    always_ff @(posedge clk) begin
        if (rst) begin
            hpos <= '0;
            lpos <= '0;
        end else if (line_end) begin
            hpos <= '0;
            lpos <= row_end ? '0 : lpos + 1'b1;
        end else begin
            hpos <= hpos + 1'b1;
        end
    end

    a_r1_line_restart: assert property (@(posedge clk) disable iff (rst)
        line_end |=> (hpos == '0));
    a_r1_hpos_advance: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> (hpos == $past(hpos) + 1'b1));
    a_r1_row_restart: assert property (@(posedge clk) disable iff (rst)
        row_end |=> (lpos == '0));
endmodule

// File: rtl/tfs_slot_arb.sv
module tfs_slot_arb
    import tfs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [HT_W-1:0] hpos,
    input  logic [SL_W-1:0] lpos,
    input  logic [HD_W-1:0] hdisp,
    input  logic [RF_W-1:0] refresh,
    input  logic [SL_W-1:0] row_lines,
    input  logic            interlace,
    input  logic [PF_W-1:0] pf_cnt,
    input  logic [PF_W-1:0] pf_tot,
    output slot_kind_e      kind,
    output logic [HD_W-1:0] col,
    output logic            in_attr
);
    logic [CW-1:0]   h_w, bm_last, rf_last;
    logic [SL_W:0]   half;
    logic [PF_W-1:0] seg, off;
    logic            is_bm, is_rf, line_ok, pf_go;

    assign h_w     = CW'(hpos);
    assign bm_last = CW'(hdisp);
    assign rf_last = CW'(hdisp) + CW'(refresh);
    assign is_bm   = (h_w <= bm_last);
    assign is_rf   = !is_bm && (h_w <= rf_last);
    assign half    = ({1'b0, row_lines} + 1'b1) >> 1;
    assign line_ok = !interlace || ({1'b0, lpos} < half);
    assign pf_go   = !is_bm && !is_rf && line_ok && (pf_cnt < pf_tot);
    assign seg     = seg_len(hdisp);
    assign in_attr = (pf_cnt >= seg);
    assign off     = in_attr ? pf_cnt - seg : pf_cnt;
    assign col     = HD_W'(off - PF_W'(SETUP_CYC));

    always_comb begin
        if (is_bm)                        kind = K_BITMAP;
        else if (is_rf)                   kind = K_REFRESH;
        else if (!pf_go)                  kind = K_IDLE;
        else if (off < PF_W'(SETUP_CYC))  kind = K_SETUP;
        else if (in_attr)                 kind = K_ATTR;
        else                              kind = K_CHAR;
    end

    // R6: late lines of an interlaced row never carry prefetch work
    a_r6_field_lines: assert property (@(posedge clk) disable iff (rst)
        (interlace && ({1'b0, lpos} >= half)) |-> !(kind inside {K_SETUP, K_CHAR, K_ATTR}));
    a_r2_bitmap_first: assert property (@(posedge clk) disable iff (rst)
        (hpos == '0) |-> (kind == K_BITMAP));
endmodule

// File: rtl/tfs_prefetch_ctl.sv
module tfs_prefetch_ctl
    import tfs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  slot_kind_e      kind,
    input  logic            row_end,
    input  logic [HD_W-1:0] hdisp,
    input  logic            attr_en,
    output logic [PF_W-1:0] pf_cnt,
    output logic [PF_W-1:0] pf_tot,
    output logic            fill_bank,
    output logic            underrun,
    output logic [AW-1:0]   row_base,
    output logic [RF_W-1:0] rfsh_addr
);
    logic            pf_step;
    logic [PF_W-1:0] pf_nxt;

    assign pf_tot  = pf_total(hdisp, attr_en);
    assign pf_step = (kind inside {K_SETUP, K_CHAR, K_ATTR});
    assign pf_nxt  = pf_cnt + PF_W'(pf_step);

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_cnt    <= '0;
            fill_bank <= 1'b0;
            underrun  <= 1'b0;
            row_base  <= '0;
            rfsh_addr <= '0;
        end else begin
            if (kind == K_REFRESH) rfsh_addr <= rfsh_addr + 1'b1;
            if (row_end) begin
                pf_cnt    <= '0;
                fill_bank <= ~fill_bank;
                underrun  <= (pf_nxt < pf_tot);
                row_base  <= row_base + AW'(hdisp) + 1'b1;
            end else begin
                pf_cnt    <= pf_nxt;
            end
        end
    end

    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        pf_cnt <= pf_tot);
    a_r9_bank_swap: assert property (@(posedge clk) disable iff (rst)
        row_end |=> (fill_bank != $past(fill_bank)));
    a_r9_bank_hold: assert property (@(posedge clk) disable iff (rst)
        !row_end |=> $stable(fill_bank));
    a_r10_flag_hold: assert property (@(posedge clk) disable iff (rst)
        !row_end |=> $stable(underrun));
    a_r3_rfsh_step: assert property (@(posedge clk) disable iff (rst)
        (kind == K_REFRESH) |=> (rfsh_addr == $past(rfsh_addr) + 1'b1));
endmodule

// File: rtl/text_row_fetch_sched.sv
module text_row_fetch_sched
    import tfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [HT_W-1:0]  htotal,
    input  logic [HD_W-1:0]  hdisp,
    input  logic [RF_W-1:0]  refresh,
    input  logic [SL_W-1:0]  row_lines,
    input  logic             interlace,
    input  logic             attr_en,
    input  logic [AW-1:0]    char_base,
    input  logic [AW-1:0]    attr_base,
    output logic             mem_req,
    output logic [2:0]       mem_kind,
    output logic [AW-1:0]    mem_addr,
    output logic             wr_en,
    output logic             wr_attr,
    output logic [IDX_W-1:0] wr_idx,
    output logic             wr_bank,
    output logic             disp_bank,
    output logic             underrun
);
    logic [HT_W-1:0] hpos;
    logic [SL_W-1:0] lpos;
    logic            line_end, row_end, in_attr, fill_bank;
    logic [PF_W-1:0] pf_cnt, pf_tot;
    logic [HD_W-1:0] col;
    logic [AW-1:0]   row_base;
    logic [RF_W-1:0] rfsh_addr;
    slot_kind_e      kind;
    buf_loc_t        loc;

    tfs_line_timer u_timer (
        .clk(clk), .rst(rst), .htotal(htotal), .row_lines(row_lines),
        .hpos(hpos), .lpos(lpos), .line_end(line_end), .row_end(row_end)
    );

    tfs_slot_arb u_arb (
        .clk(clk), .rst(rst), .hpos(hpos), .lpos(lpos), .hdisp(hdisp),
        .refresh(refresh), .row_lines(row_lines), .interlace(interlace),
        .pf_cnt(pf_cnt), .pf_tot(pf_tot), .kind(kind), .col(col), .in_attr(in_attr)
    );

    tfs_prefetch_ctl u_pf (
        .clk(clk), .rst(rst), .kind(kind), .row_end(row_end), .hdisp(hdisp),
        .attr_en(attr_en), .pf_cnt(pf_cnt), .pf_tot(pf_tot), .fill_bank(fill_bank),
        .underrun(underrun), .row_base(row_base), .rfsh_addr(rfsh_addr)
    );

    assign mem_kind  = kind;
    assign mem_req   = (kind inside {K_BITMAP, K_REFRESH, K_CHAR, K_ATTR});
    assign loc       = map_col(col, in_attr);
    assign wr_en     = (kind inside {K_CHAR, K_ATTR});
    assign wr_attr   = loc.attr;
    assign wr_idx    = loc.idx;
    assign wr_bank   = fill_bank;
    assign disp_bank = ~fill_bank;

    always_comb begin
        case (kind)
            K_BITMAP:  mem_addr = AW'(hpos);
            K_REFRESH: mem_addr = AW'(rfsh_addr);
            K_CHAR:    mem_addr = char_base + row_base + AW'(col);
            K_ATTR:    mem_addr = attr_base + row_base + AW'(col);
            default:   mem_addr = '0;
        endcase
    end

    a_r7_idx_range: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < BUF_DEPTH));
    a_r5_attr_gate: assert property (@(posedge clk) disable iff (rst)
        !attr_en |-> (kind != K_ATTR));
endmodule

// File: tb/text_row_fetch_sched_tb.sv
`timescale 1ns/1ps
module text_row_fetch_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  htotal = 8'd40;
    logic [6:0]  hdisp = 7'd19;
    logic [7:0]  refresh = 8'd5;
    logic [4:0]  row_lines = 5'd7;
    logic        interlace = 1'b0;
    logic        attr_en = 1'b0;
    logic [15:0] char_base = 16'h0000;
    logic [15:0] attr_base = 16'h0000;
    logic        mem_req, wr_en, wr_attr, wr_bank, disp_bank, underrun;
    logic [2:0]  mem_kind;
    logic [15:0] mem_addr;
    logic [6:0]  wr_idx;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    text_row_fetch_sched dut_i (
        .clk(clk), .rst(rst), .htotal(htotal), .hdisp(hdisp), .refresh(refresh),
        .row_lines(row_lines), .interlace(interlace), .attr_en(attr_en),
        .char_base(char_base), .attr_base(attr_base), .mem_req(mem_req),
        .mem_kind(mem_kind), .mem_addr(mem_addr), .wr_en(wr_en), .wr_attr(wr_attr),
        .wr_idx(wr_idx), .wr_bank(wr_bank), .disp_bank(disp_bank), .underrun(underrun)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_cfg(input int ht, input int hd, input int rf, input int rl,
                           input bit il, input bit at, input int cb, input int ab);
        int mh, msl, mpf, mrf, mrs, seg, tot, rowc, free, lines, half;
        int ek, ea, c, pstep;
        bit mbank, mund, exp_und, bm, rfs, av, pa;
        rst = 1'b1;
        htotal = 8'(ht); hdisp = 7'(hd); refresh = 8'(rf); row_lines = 5'(rl);
        interlace = il; attr_en = at; char_base = 16'(cb); attr_base = 16'(ab);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mh = 0; msl = 0; mpf = 0; mrf = 0; mrs = 0; mbank = 0; mund = 0;
        // R11: state right after reset
        chk(mem_kind == 3'd1 && mem_addr == 16'd0, "R11 first slot", int'(mem_kind), 1);
        chk(underrun == 1'b0, "R11 underrun", int'(underrun), 0);
        chk(wr_bank == 1'b0 && disp_bank == 1'b1, "R11 bank", int'(wr_bank), 0);
        seg = hd + 5;
        tot = at ? 2 * seg : seg;
        rowc = (ht + 1) * (rl + 1);
        free = ht + 1 - (hd + 1) - rf;
        if (free < 0) free = 0;
        half = (rl + 1) / 2;
        lines = il ? half : rl + 1;
        exp_und = (free * lines) < tot;
        for (int n = 0; n < 3 * rowc; n++) begin
            bm  = (mh <= hd);
            rfs = !bm && (mh <= hd + rf);
            av  = !il || (msl < half);
            pa  = !bm && !rfs && av && (mpf < tot);
            c = 0; ea = 0;
            if (bm) begin ek = 1; ea = mh; end
            else if (rfs) begin ek = 2; ea = mrf; end
            else if (!pa) ek = 0;
            else begin
                int off;
                bit second;
                second = (mpf >= seg);
                off = second ? mpf - seg : mpf;
                if (off < 4) ek = 3;
                else begin
                    c = off - 4;
                    ek = second ? 5 : 4;
                    ea = ((second ? ab : cb) + mrs + c) & 16'hFFFF;
                end
            end
            if (mh == 0) chk(mem_kind == 3'd1, "R1 line start", int'(mem_kind), 1);
            case (ek)
                1: begin
                    chk(mem_kind == 3'd1, "R2 bitmap slot", int'(mem_kind), ek);
                    chk(mem_addr == 16'(ea), "R2 bitmap addr", int'(mem_addr), ea);
                end
                2: begin
                    chk(mem_kind == 3'd2, "R3 refresh slot", int'(mem_kind), ek);
                    chk(mem_addr == 16'(ea), "R3 refresh addr", int'(mem_addr), ea);
                end
                3: chk(mem_kind == 3'd3 && mem_addr == 16'd0, "R4 setup slot", int'(mem_kind), ek);
                4: begin
                    chk(mem_kind == 3'd4, "R4 char slot", int'(mem_kind), ek);
                    chk(mem_addr == 16'(ea), "R8 char addr", int'(mem_addr), ea);
                end
                5: begin
                    chk(mem_kind == 3'd5, "R5 attr slot", int'(mem_kind), ek);
                    chk(mem_addr == 16'(ea), "R8 attr addr", int'(mem_addr), ea);
                end
                default: chk(mem_kind == 3'd0, il ? "R6 idle slot" : "R4 idle slot",
                             int'(mem_kind), 0);
            endcase
            chk(mem_req == (ek == 1 || ek == 2 || ek == 4 || ek == 5), "R2 request",
                int'(mem_req), int'(ek == 1 || ek == 2 || ek == 4 || ek == 5));
            chk(wr_en == (ek >= 4), "R7 write strobe", int'(wr_en), int'(ek >= 4));
            if (ek >= 4) begin
                int eidx;
                bit eat;
                if (c >= 82) begin eat = 1; eidx = c - 81; end
                else begin eat = (ek == 5); eidx = c; end
                chk(wr_attr == eat && wr_idx == 7'(eidx), "R7 buffer index",
                    int'(wr_attr) * 128 + int'(wr_idx), int'(eat) * 128 + eidx);
            end
            chk(wr_bank == mbank && disp_bank == !mbank, "R9 bank", int'(wr_bank), int'(mbank));
            chk(underrun == mund, "R10 flag", int'(underrun), int'(mund));
            if (n == rowc)
                chk(underrun == exp_und, "R10 budget", int'(underrun), int'(exp_und));
            // advance the model across the coming clock edge
            pstep = (ek >= 3) ? 1 : 0;
            if (ek == 2) mrf = (mrf + 1) & 8'hFF;
            if (mh >= ht) begin
                mh = 0;
                if (msl >= rl) begin
                    msl = 0;
                    mund = (mpf + pstep) < tot;
                    mpf = 0;
                    mbank = !mbank;
                    mrs = (mrs + hd + 1) & 16'hFFFF;
                end else begin
                    msl++;
                    mpf += pstep;
                end
            end else begin
                mh++;
                mpf += pstep;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        run_cfg(40, 19, 5, 7, 0, 1, 16'h1000, 16'h2000);
        run_cfg(40, 19, 5, 7, 1, 1, 16'h1000, 16'h2000);
        run_cfg(31, 19, 5, 7, 1, 1, 16'h0100, 16'h0800);
        run_cfg(31, 19, 5, 7, 1, 0, 16'h0100, 16'h0800);
        run_cfg(31, 19, 6, 7, 0, 1, 16'hFFF0, 16'h4000);  // R10 exact fit, last fetch on boundary
        run_cfg(31, 19, 7, 7, 0, 1, 16'hFFF0, 16'h4000);  // R10 one cycle short per line
        run_cfg(31, 19, 0, 7, 1, 1, 16'h0000, 16'h0800);  // R3 no refresh frees cycles
        run_cfg(120, 90, 3, 7, 0, 1, 16'h3000, 16'h5000); // R7 columns past 81 spill
        run_cfg(63, 40, 0, 7, 1, 1, 16'h0200, 16'h0A00);
        run_cfg(40, 9, 2, 0, 0, 0, 16'h0040, 16'h0000);
        run_cfg(40, 9, 2, 0, 1, 0, 16'h0040, 16'h0000);  // R6 single-line row in interlace
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule